// File: doc/BRIEF.md
# MII Nibble Receive Frame Controller

This block is the receive front end of a 10/100 Ethernet MAC. It takes one 4-bit nibble per receive clock from the media-independent interface, together with the data-valid and error strobes. Each nibble passes through a two-stage register pipeline. The first stage feeds the delimiter search and the address comparison on every cycle. The second stage reaches the downstream FIFO only while the forwarding enable is high. At all other times the FIFO data bus floats.

When data-valid rises, the controller raises a hunt request and searches for the start frame delimiter nibble. After the delimiter it does the following:

- It compares the destination address with a programmed host address, one nibble at a time.
- It captures the length/type field.
- It runs a nibble-wide CRC-32 over every frame nibble.

When data-valid falls, the controller writes a one-cycle status record. The record holds the byte count and four error flags, which downstream logic uses to accept or discard what the FIFO received.

Top module: `mii_rx_frame`

## Requirements
- R1: A synchronous active-high reset clears the input pipeline, the hunt request, the delimiter pulse, the forwarding enable, the status strobe and the status flags.
- R2: After `rx_dv` rises, `hunt` goes high within three clock edges and stays high through the preamble. While `hunt` is high, `fifo_en` is low.
- R3: While `fifo_en` is low, `fifo_data` is not driven (high impedance).
- R4: Each frame nibble sampled after the delimiter appears on `fifo_data` two clock edges after it was sampled, in arrival order, with `fifo_en` high. Forwarding continues until the frame ends or a stop condition from R7 or R8 occurs.
- R5: `hunt` drops once the delimiter is found. If `rx_dv` falls while hunting, `hunt` drops, the block returns to idle, and no status is written.
- R6: While hunting, a sampled nibble of value 4'hD (bits 0..3 received as 1,0,1,1) produces exactly one single-cycle `sfd_hit` pulse, one edge after the hunt ends.
- R7: Frame nibble k (k = 0..11, counted from the first nibble after the delimiter) is compared with `host_addr[4k+3:4k]`. On the first mismatch, `stat_flags[2]` is set and no nibble from that one onward is forwarded.
- R8: `rx_er` high on a frame nibble sets `stat_flags[3]`, and no nibble from that one onward is forwarded.
- R9: On the edge after the block sees `rx_dv` low in a frame, `stat_valid` pulses for one cycle. `stat_bytes` then equals the number of frame nibbles (after the delimiter, FCS included) divided by two.
- R10: The length/type value is byte 12 (high) followed by byte 13 (low), each byte taken low nibble first. `stat_flags[1]` is set in any of these cases:
  - the frame has fewer than 18 bytes;
  - the value is at most 1500 and the payload (bytes minus 18) differs from the larger of the value and 46;
  - the value lies between 1501 and 1535.
- R11: A CRC-32 (polynomial 0x04C11DB7, register preset to all ones, bit 0 of each nibble first) runs over all frame nibbles. `stat_flags[0]` is set unless the residue in polynomial order equals 0xC704DD7B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MII receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 4 | Receive nibble |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error strobe |
| host_addr | input | 48 | Programmed host address, byte i in bits [8i+7:8i] |
| fifo_data | output | 4 | Forwarded nibble, high impedance when not enabled |
| fifo_en | output | 1 | Forwarding enable / FIFO write strobe |
| hunt | output | 1 | Delimiter search request |
| sfd_hit | output | 1 | Single-cycle delimiter detected pulse |
| stat_valid | output | 1 | Status record written this cycle |
| stat_bytes | output | 12 | Received byte count |
| stat_flags | output | 4 | [0] FCS, [1] length, [2] address miss, [3] receive error |

## Verification
The assertions assume the following about the inputs:

- every frame is a preamble of 4'h5 nibbles, a single 4'hD nibble, and an even number of frame nibbles;
- `rx_dv` stays low for several cycles between frames;
- `rx_er` is raised only on frame nibbles.

The stimulus generator builds every frame in that shape. It varies the payload length, the field kind, address matching, error placement, truncation and bit corruption, which are picked with `$urandom` from a fixed seed. The bench derives its expectations from the frame bytes it actually sent.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HUNT, ST_BODY} rx_state_e;

  localparam logic [3:0]  SFD_NIB     = 4'hD;
  localparam logic [31:0] POLY_REFL   = 32'hEDB88320;
  // 0xC704DD7B held bit-reversed, matching the shift-right register
  localparam logic [31:0] RESIDUE_REF = 32'hDEBB20E3;

  function automatic logic [31:0] crc_step_nib(input logic [31:0] c, input logic [3:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 4; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/mii_rx_pipe.sv
module mii_rx_pipe #(
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] rxd,
  input  logic          rx_dv,
  input  logic          rx_er,
  output logic [NW-1:0] s1_nib,
  output logic [NW-1:0] s2_nib,
  output logic          s1_dv,
  output logic          s1_er
);
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_nib <= '0;
      s2_nib <= '0;
      s1_dv  <= 1'b0;
      s1_er  <= 1'b0;
    end else begin
      s1_nib <= rxd;
      s2_nib <= s1_nib;
      s1_dv  <= rx_dv;
      s1_er  <= rx_er;
    end
  end
endmodule

// File: rtl/mii_rx_sfd.sv
module mii_rx_sfd
  import mii_rx_pkg::*;
#(
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hunt,
  input  logic          dv,
  input  logic [NW-1:0] nib,
  output logic          match,
  output logic          hit
);
  assign match = hunt && dv && (nib == NW'(SFD_NIB));

  always_ff @(posedge clk) begin
    if (rst) hit <= 1'b0;
    else     hit <= match;
  end
endmodule

// File: rtl/mii_rx_crc.sv
module mii_rx_crc
  import mii_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        en,
  input  logic [3:0]  nib,
  output logic        residue_ok
);
  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || clear) crc_q <= '1;
    else if (en)      crc_q <= crc_step_nib(crc_q, nib);
  end

  assign residue_ok = (crc_q == RESIDUE_REF);
endmodule

// File: rtl/mii_rx_frame.sv
module mii_rx_frame
  import mii_rx_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int CNT_W     = 13,
  parameter int HDR_BYTES = 14,
  parameter int FCS_BYTES = 4,
  parameter int MAX_LEN   = 1500,
  parameter int MIN_TYPE  = 1536,
  parameter int MIN_PAY   = 46
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        rxd,
  input  logic              rx_dv,
  input  logic              rx_er,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [3:0]        fifo_data,
  output logic              fifo_en,
  output logic              hunt,
  output logic              sfd_hit,
  output logic              stat_valid,
  output logic [CNT_W-2:0]  stat_bytes,
  output logic [3:0]        stat_flags
);
  localparam int ADDR_NIBS = ADDR_W / 4;
  localparam int LEN_NIB   = 2 * (HDR_BYTES - 2);
  localparam int MIN_BYTES = HDR_BYTES + FCS_BYTES;
  localparam int LW        = 17;

  rx_state_e        state;
  logic [3:0]       s1, s2;
  logic             dv1, er1, sfd_match, crc_ok;
  logic [CNT_W-1:0] nib_cnt;
  logic             kill, f_addr, f_phy;
  logic [15:0]      len_q;
  logic [3:0]       host_nib;
  logic             addr_bad, len_bad;
  logic [LW-1:0]    nbytes, pay, len_x, exp_pay;

  assign hunt = (state == ST_HUNT);

  mii_rx_pipe #(.NW(4)) u_pipe (
    .clk(clk), .rst(rst), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
    .s1_nib(s1), .s2_nib(s2), .s1_dv(dv1), .s1_er(er1)
  );

  mii_rx_sfd #(.NW(4)) u_sfd (
    .clk(clk), .rst(rst), .hunt(hunt), .dv(dv1), .nib(s1),
    .match(sfd_match), .hit(sfd_hit)
  );

  mii_rx_crc u_crc (
    .clk(clk), .rst(rst), .clear(sfd_match),
    .en(state == ST_BODY && dv1), .nib(s1), .residue_ok(crc_ok)
  );

  // host nibble selected by the current frame nibble index
  always_comb begin
    host_nib = '0;
    for (int k = 0; k < ADDR_NIBS; k++)
      if (nib_cnt == CNT_W'(k)) host_nib = host_addr[4*k +: 4];
  end
  assign addr_bad = (nib_cnt < CNT_W'(ADDR_NIBS)) && (s1 != host_nib);

  // length / type rule evaluated at end of frame
  always_comb begin
    nbytes  = LW'(nib_cnt >> 1);
    pay     = nbytes - LW'(MIN_BYTES);
    len_x   = LW'(len_q);
    exp_pay = (len_x < LW'(MIN_PAY)) ? LW'(MIN_PAY) : len_x;
    if (nbytes < LW'(MIN_BYTES))    len_bad = 1'b1;
    else if (len_x <= LW'(MAX_LEN)) len_bad = (pay != exp_pay);
    else if (len_x < LW'(MIN_TYPE)) len_bad = 1'b1;
    else                            len_bad = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      nib_cnt    <= '0;
      kill       <= 1'b0;
      f_addr     <= 1'b0;
      f_phy      <= 1'b0;
      len_q      <= '0;
      fifo_en    <= 1'b0;
      stat_valid <= 1'b0;
      stat_bytes <= '0;
      stat_flags <= '0;
    end else begin
      stat_valid <= 1'b0;
      fifo_en    <= 1'b0;
      case (state)
        ST_IDLE: if (dv1) state <= ST_HUNT;
        ST_HUNT: begin
          if (!dv1) state <= ST_IDLE;
          else if (sfd_match) begin
            state   <= ST_BODY;
            nib_cnt <= '0;
            kill    <= 1'b0;
            f_addr  <= 1'b0;
            f_phy   <= 1'b0;
            len_q   <= '0;
          end
        end
        ST_BODY: begin
          if (dv1) begin
            nib_cnt <= nib_cnt + 1'b1;
            if (er1)             f_phy  <= 1'b1;
            if (addr_bad)        f_addr <= 1'b1;
            if (er1 || addr_bad) kill   <= 1'b1;
            fifo_en <= !(kill || er1 || addr_bad);
            if (nib_cnt == CNT_W'(LEN_NIB))     len_q[11:8]  <= s1;
            if (nib_cnt == CNT_W'(LEN_NIB + 1)) len_q[15:12] <= s1;
            if (nib_cnt == CNT_W'(LEN_NIB + 2)) len_q[3:0]   <= s1;
            if (nib_cnt == CNT_W'(LEN_NIB + 3)) len_q[7:4]   <= s1;
          end else begin
            stat_valid <= 1'b1;
            stat_bytes <= nib_cnt[CNT_W-1:1];
            stat_flags <= {f_phy, f_addr, len_bad, !crc_ok};
            state      <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign fifo_data = fifo_en ? s2 : 4'bzzzz;
endmodule

// File: rtl/mii_rx_frame_chk.sv
module mii_rx_frame_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] rxd,
  input logic       rx_dv,
  input logic       rx_er,
  input logic       fifo_en,
  input logic       hunt,
  input logic       sfd_hit,
  input logic       stat_valid
);
  p_quiet_while_hunt_r2: assert property (@(posedge clk) disable iff (rst)
    hunt |-> !fifo_en);

  p_fwd_needs_dv_r4: assert property (@(posedge clk) disable iff (rst)
    fifo_en |-> ($past(rx_dv, 2) && !$past(rx_er, 2)));

  p_hunt_off_at_sfd_r5: assert property (@(posedge clk) disable iff (rst)
    sfd_hit |-> !hunt);

  p_sfd_nibble_r6: assert property (@(posedge clk) disable iff (rst)
    sfd_hit |-> ($past(rxd, 2) == 4'hD && $past(hunt)));

  p_stat_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    stat_valid |=> !stat_valid);
endmodule

bind mii_rx_frame mii_rx_frame_chk u_chk (
  .clk(clk), .rst(rst), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
  .fifo_en(fifo_en), .hunt(hunt), .sfd_hit(sfd_hit), .stat_valid(stat_valid)
);

// File: tb/tb_mii_rx_frame.sv
`timescale 1ns/1ps
module tb_mii_rx_frame;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rxd = '0;
  logic        rx_dv = 1'b0;
  logic        rx_er = 1'b0;
  logic [47:0] host_addr;
  wire  [3:0]  fifo_data;
  logic        fifo_en, hunt, sfd_hit, stat_valid;
  logic [11:0] stat_bytes;
  logic [3:0]  stat_flags;

  mii_rx_frame dut (
    .clk(clk), .rst(rst), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
    .host_addr(host_addr), .fifo_data(fifo_data), .fifo_en(fifo_en),
    .hunt(hunt), .sfd_hit(sfd_hit), .stat_valid(stat_valid),
    .stat_bytes(stat_bytes), .stat_flags(stat_flags)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] fr [0:1023];
  int flen;
  logic [3:0] obs [0:4095];
  int obs_n = 0, sfd_n = 0, stat_n = 0;
  logic [11:0] st_b;
  logic [3:0]  st_f;
  bit z_bad = 1'b0;

  // a two-state simulator resolves a floating bus to zero
  always @(negedge clk) if (!rst) begin
    if (fifo_en) begin obs[obs_n] = fifo_data; obs_n++; end
    else if (!(fifo_data === 4'bzzzz || fifo_data === 4'b0000)) z_bad = 1'b1;
    if (sfd_hit) sfd_n++;
    if (stat_valid) begin stat_n++; st_b = stat_bytes; st_f = stat_flags; end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] nib_at(input int i);
    return i[0] ? fr[i >> 1][7:4] : fr[i >> 1][3:0];
  endfunction

  function automatic logic [31:0] fcs_of(input int n);
    logic [31:0] c = '1;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ fr[i][b];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    return ~c;
  endfunction

  function automatic bit exp_len(input int nb, input int lf);
    if (nb < 18) return 1'b1;
    if (lf <= 1500) return (nb - 18) != ((lf < 46) ? 46 : lf);
    if (lf < 1536) return 1'b1;
    return 1'b0;
  endfunction

  task automatic add_fcs();
    logic [31:0] c = fcs_of(flen);
    for (int i = 0; i < 4; i++) fr[flen + i] = c[8*i +: 8];
    flen += 4;
  endtask

  // kind 0: exact length, 1: type 0x0800, 2: wrong length
  task automatic build(input int kind, input int pay, input bit da_ok);
    int n;
    logic [15:0] fld;
    for (int i = 0; i < 6; i++) fr[i] = da_ok ? host_addr[8*i +: 8] : 8'($urandom);
    for (int i = 6; i < 12; i++) fr[i] = 8'($urandom);
    n   = (kind == 0 && pay < 46) ? 46 : pay;
    fld = (kind == 0) ? 16'(pay) : (kind == 1) ? 16'h0800 : 16'(pay + 3);
    fr[12] = fld[15:8];
    fr[13] = fld[7:0];
    for (int i = 0; i < n; i++) fr[14 + i] = 8'($urandom);
    flen = 14 + n;
    add_fcs();
  endtask

  task automatic send(input int nnib, input int er_at, input bit fcs_ok, input string tag);
    int s0, ek, miss;
    bit amiss;
    obs_n = 0; sfd_n = 0; z_bad = 1'b0; s0 = stat_n;
    for (int p = 0; p < 15; p++) begin
      @(negedge clk); rxd = 4'h5; rx_dv = 1'b1; rx_er = 1'b0;
      if (p == 6) chk("R2", {tag, " hunt in preamble"}, int'(hunt), 1);
      if (p == 6) chk("R2", {tag, " no forwarding while hunting"}, int'(fifo_en), 0);
    end
    @(negedge clk); rxd = 4'hD;
    for (int i = 0; i < nnib; i++) begin
      @(negedge clk); rxd = nib_at(i); rx_er = (i == er_at);
      if (i == 2) chk("R5", {tag, " hunt dropped after SFD"}, int'(hunt), 0);
    end
    @(negedge clk); rx_dv = 1'b0; rx_er = 1'b0; rxd = '0;
    repeat (8) @(negedge clk);
    ek = nnib; amiss = 1'b0;
    for (int i = 0; i < nnib; i++) begin
      bit am = (i < 12) && (nib_at(i) != host_addr[4*i +: 4]);
      if (am) amiss = 1'b1;
      if ((i == er_at || am) && ek == nnib) ek = i;
    end
    miss = 0;
    for (int i = 0; i < ek && i < obs_n; i++) if (obs[i] != nib_at(i)) miss++;
    chk("R6", {tag, " sfd pulses"}, sfd_n, 1);
    chk("R4", {tag, " forwarded count"}, obs_n, ek);
    chk("R4", {tag, " forwarded data errors"}, miss, 0);
    chk("R3", {tag, " bus floats when idle"}, int'(z_bad), 0);
    chk("R9", {tag, " status writes"}, stat_n - s0, 1);
    chk("R9", {tag, " byte count"}, int'(st_b), nnib / 2);
    chk("R11", {tag, " fcs flag"}, int'(st_f[0]), int'(!(fcs_ok && nnib == 2 * flen)));
    chk("R10", {tag, " length flag"}, int'(st_f[1]), int'(exp_len(nnib / 2, {fr[12], fr[13]})));
    chk("R7", {tag, " address flag"}, int'(st_f[2]), int'(amiss));
    chk("R8", {tag, " rx error flag"}, int'(st_f[3]), int'(er_at >= 0 && er_at < nnib));
  endtask

  initial begin
    int s0;
    void'($urandom(32'd4242));
    host_addr = {16'h1a2b, 32'($urandom)};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "fifo_en after reset", int'(fifo_en), 0);
    chk("R1", "hunt after reset", int'(hunt), 0);
    chk("R1", "sfd_hit after reset", int'(sfd_hit), 0);
    chk("R1", "stat_valid after reset", int'(stat_valid), 0);
    chk("R1", "stat_flags after reset", int'(stat_flags), 0);
    chk("R3", "bus after reset", int'(fifo_data === 4'bzzzz || fifo_data === 4'b0000), 1);

    build(0, 46, 1'b1); send(2 * flen, -1, 1'b1, "min length");
    build(0, 10, 1'b1); send(2 * flen, -1, 1'b1, "padded length");
    build(1, 80, 1'b1); send(2 * flen, -1, 1'b1, "type field");
    build(2, 60, 1'b1); send(2 * flen, -1, 1'b1, "wrong length");
    build(1, 50, 1'b1); fr[12] = 8'h05; fr[13] = 8'hDD; flen -= 4; add_fcs();
    send(2 * flen, -1, 1'b1, "length 1501");
    build(1, 50, 1'b1); fr[5][7:4] = ~fr[5][7:4]; flen -= 4; add_fcs();
    send(2 * flen, -1, 1'b1, "addr miss nibble 11");
    build(1, 60, 1'b1); send(2 * flen, 40, 1'b1, "rx_er mid frame");
    build(1, 60, 1'b1); send(20, -1, 1'b0, "runt");
    build(0, 70, 1'b1); fr[30] = fr[30] ^ 8'h10; send(2 * flen, -1, 1'b0, "fcs corrupt");

    // R5: data-valid drops during preamble
    s0 = stat_n; sfd_n = 0;
    for (int p = 0; p < 6; p++) begin @(negedge clk); rxd = 4'h5; rx_dv = 1'b1; end
    @(negedge clk); rx_dv = 1'b0;
    repeat (8) @(negedge clk);
    chk("R5", "hunt after aborted preamble", int'(hunt), 0);
    chk("R5", "no status after aborted preamble", stat_n - s0, 0);
    chk("R6", "no sfd after aborted preamble", sfd_n, 0);

    for (int t = 0; t < 30; t++) begin
      int kind = int'($urandom % 3);
      int pay  = int'($urandom % 120);
      int v    = int'($urandom % 6);
      build(kind, pay, ($urandom % 4) != 0);
      if (v == 0)      send(2 * flen, int'($urandom % (2 * flen)), 1'b1, "rand rx_er");
      else if (v == 1) send(2 * int'($urandom % flen), -1, 1'b1, "rand truncated");
      else if (v == 2) begin
        int j = int'($urandom % flen);
        fr[j] = fr[j] ^ (8'h1 << ($urandom % 8));
        send(2 * flen, -1, 1'b0, "rand corrupt");
      end else         send(2 * flen, -1, 1'b1, "rand clean");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog: actual 0 expected 1 frames completed");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule